// File: doc/BRIEF.md
# Two-Segment Address Relocation and Protection Unit

This block turns 32-bit virtual addresses into physical addresses for a machine whose virtual space is divided into two halves. The top address bit chooses which half is meant: a clear bit means the data segment and a set bit means the code segment. Each segment has its own relocation base, upper bound, presence bit and read/write/execute rights, all loaded by software through a small write port. Software loads them before a process starts and again at every process switch.

Every request carries an address and an access kind. One cycle later the unit returns either the relocated address or a single exception code. The code tells the operating system whether the segment must first be brought into memory, whether the offset was out of bounds, or whether the access kind was not allowed.

Control is a two-state machine. `S_IDLE` means no response is pending. `S_RESP` means a response is being presented this cycle. The transition `IDLE->RESP` and the self-loop `RESP->RESP` are taken whenever `req_valid` is high. `RESP->IDLE` and `IDLE->IDLE` are taken when it is low. The response register is loaded in the same edge as the state.

Top module: `seg_reloc_unit`

## Requirements
- R1: Address bit 31 selects the register set. 0 selects segment 0 (data) and 1 selects segment 1 (code). The offset is bits 30:0.
- R2: A request with `req_valid` high gives `rsp_valid` high for exactly one cycle in the next cycle. In that cycle, a permitted access reports `rsp_exc` = 0 and `rsp_paddr` = base + offset. When no response is pending, `rsp_exc` and `rsp_paddr` are 0.
- R3: An offset greater than or equal to the selected limit gives `rsp_exc` = 2 (bounds).
- R4: If base + offset carries out of 32 bits, the result is `rsp_exc` = 2 (bounds).
- R5: Access kind 0 = read needs flag bit 0. Kind 1 = write needs flag bit 1. Kind 2 = execute needs flag bit 2. Kind 3 is never permitted. A missing right gives `rsp_exc` = 3.
- R6: Flag bit 3 is the presence bit. A clear presence bit gives `rsp_exc` = 1 (segment absent).
- R7: Only one code is reported per access. Absent takes priority over bounds, and bounds takes priority over rights.
- R8: `cfg_sel` bit 2 selects the segment and bits 1:0 select the field: 0 = base, 1 = limit, 2 = flags. Field value 3 is ignored. A write takes effect for requests in later cycles only; a request in the same cycle still sees the old value.
- R9: Reset clears all registers. `rsp_valid`, `rsp_exc` and `rsp_paddr` are then 0, so the first access after reset reports code 1.
- R10: Whenever an exception is reported, `rsp_paddr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select: segment in bit 2, field in bits 1:0 |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Request pulse |
| req_addr | input | 32 | Virtual address |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| rsp_valid | output | 1 | Response pulse, one cycle after the request |
| rsp_exc | output | 2 | 0 none, 1 absent, 2 bounds, 3 rights |
| rsp_paddr | output | 32 | Physical address, 0 on exception |

## Verification
The following are checked on every cycle against the live register contents:
- the one-cycle request-to-response pulse;
- the zeroed outputs when idle or faulting;
- the absent and bounds outcomes;
- that every fault-free response holds base plus offset and had the right in question.

Only the bench scenarios can show the following:
- the priority between overlapping faults with concrete values;
- carry-out detection at the top of the physical space;
- that writes to the unused field select change nothing;
- that a write and a request in the same cycle resolve to the old value.

// File: rtl/seg_pkg.sv
package seg_pkg;
    typedef enum logic [1:0] {
        EXC_NONE   = 2'd0,
        EXC_ABSENT = 2'd1,
        EXC_BOUND  = 2'd2,
        EXC_RIGHTS = 2'd3
    } exc_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        FLD_BASE  = 2'd0,
        FLD_LIMIT = 2'd1,
        FLD_FLAGS = 2'd2,
        FLD_NONE  = 2'd3
    } fld_e;

    localparam int FLAG_W   = 4;
    localparam int FLAG_RD  = 0;
    localparam int FLAG_WR  = 1;
    localparam int FLAG_EX  = 2;
    localparam int FLAG_PRS = 3;
    localparam int NSEG     = 2;
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
    import seg_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                we,
    input  logic [2:0]                          sel,
    input  logic [ADDR_W-1:0]                   wdata,
    output logic [NSEG-1:0][ADDR_W-1:0]         base_q,
    output logic [NSEG-1:0][ADDR_W-1:0]         limit_q,
    output logic [NSEG-1:0][FLAG_W-1:0]         flags_q
);
    fld_e field;
    assign field = fld_e'(sel[1:0]);

    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        logic hit;
        assign hit = we && (sel[2] == g[0]);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[g]  <= '0;
                limit_q[g] <= '0;
                flags_q[g] <= '0;
            end else if (hit) begin
                unique case (field)
                    FLD_BASE:  base_q[g]  <= wdata;
                    FLD_LIMIT: limit_q[g] <= wdata;
                    FLD_FLAGS: flags_q[g] <= wdata[FLAG_W-1:0];
                    FLD_NONE:  ;
                endcase
            end
        end
    end
endmodule

// File: rtl/seg_access_check.sv
module seg_access_check
    import seg_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        kind,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] limit,
    input  logic [FLAG_W-1:0] flags,
    output exc_e              exc,
    output logic [ADDR_W-1:0] paddr
);
    localparam int OFF_W = ADDR_W - 1;

    logic [ADDR_W-1:0] offset;
    logic [ADDR_W:0]   sum;
    logic              present, out_of_range, carry, permitted;

    assign offset       = {1'b0, addr[OFF_W-1:0]};
    assign sum          = {1'b0, base} + {1'b0, offset};
    assign carry        = sum[ADDR_W];
    assign present      = flags[FLAG_PRS];
    assign out_of_range = (offset >= limit) || carry;

    always_comb begin
        unique case (acc_e'(kind))
            ACC_READ:  permitted = flags[FLAG_RD];
            ACC_WRITE: permitted = flags[FLAG_WR];
            ACC_EXEC:  permitted = flags[FLAG_EX];
            ACC_RSVD:  permitted = 1'b0;
        endcase
    end

    always_comb begin
        paddr = '0;
        if (!present)          exc = EXC_ABSENT;
        else if (out_of_range) exc = EXC_BOUND;
        else if (!permitted)   exc = EXC_RIGHTS;
        else begin
            exc   = EXC_NONE;
            paddr = sum[ADDR_W-1:0];
        end
    end
endmodule

// File: rtl/seg_reloc_unit.sv
module seg_reloc_unit
    import seg_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_kind,
    output logic              rsp_valid,
    output logic [1:0]        rsp_exc,
    output logic [ADDR_W-1:0] rsp_paddr
);
    localparam int SEG_BIT = ADDR_W - 1;

    typedef enum logic [0:0] {S_IDLE = 1'b0, S_RESP = 1'b1} state_e;

    state_e state_q, state_d;

    logic [NSEG-1:0][ADDR_W-1:0] base_q;
    logic [NSEG-1:0][ADDR_W-1:0] limit_q;
    logic [NSEG-1:0][FLAG_W-1:0] flags_q;

    logic              seg_idx;
    exc_e              chk_exc;
    logic [ADDR_W-1:0] chk_paddr;

    seg_regfile #(.ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .sel     (cfg_sel),
        .wdata   (cfg_wdata),
        .base_q  (base_q),
        .limit_q (limit_q),
        .flags_q (flags_q)
    );

    assign seg_idx = req_addr[SEG_BIT];

    seg_access_check #(.ADDR_W(ADDR_W)) u_check (
        .addr  (req_addr),
        .kind  (req_kind),
        .base  (base_q[seg_idx]),
        .limit (limit_q[seg_idx]),
        .flags (flags_q[seg_idx]),
        .exc   (chk_exc),
        .paddr (chk_paddr)
    );

    always_comb begin
        unique case (state_q)
            S_IDLE:  state_d = req_valid ? S_RESP : S_IDLE;
            S_RESP:  state_d = req_valid ? S_RESP : S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_exc   <= EXC_NONE;
            rsp_paddr <= '0;
        end else if (state_d == S_RESP) begin
            rsp_exc   <= chk_exc;
            rsp_paddr <= chk_paddr;
        end else begin
            rsp_exc   <= EXC_NONE;
            rsp_paddr <= '0;
        end
    end

    assign rsp_valid = (state_q == S_RESP);
endmodule

// File: rtl/seg_reloc_checks.sv
module seg_reloc_checks
    import seg_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        req_valid,
    input logic [ADDR_W-1:0]           req_addr,
    input logic [1:0]                  req_kind,
    input logic                        rsp_valid,
    input logic [1:0]                  rsp_exc,
    input logic [ADDR_W-1:0]           rsp_paddr,
    input logic [NSEG-1:0][ADDR_W-1:0] base_q,
    input logic [NSEG-1:0][ADDR_W-1:0] limit_q,
    input logic [NSEG-1:0][FLAG_W-1:0] flags_q
);
    logic              s;
    logic [ADDR_W-1:0] off;
    assign s   = req_addr[ADDR_W-1];
    assign off = {1'b0, req_addr[ADDR_W-2:0]};

    assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_rsp_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid));

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_exc == 2'd0 && rsp_paddr == '0));

    assert_absent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !flags_q[s][FLAG_PRS]) |=> rsp_exc == 2'd1);

    assert_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && flags_q[s][FLAG_PRS] && off >= limit_q[s]) |=> rsp_exc == 2'd2);

    assert_fault_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_exc != 2'd0) |-> rsp_paddr == '0);

    assert_reloc_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_exc == 2'd0) |-> rsp_paddr == $past(base_q[s] + off));

    assert_rights_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_exc == 2'd0) |-> ($past(req_kind) != 2'd3 && $past(flags_q[s][req_kind])));
endmodule

bind seg_reloc_unit seg_reloc_checks #(.ADDR_W(ADDR_W)) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_kind  (req_kind),
    .rsp_valid (rsp_valid),
    .rsp_exc   (rsp_exc),
    .rsp_paddr (rsp_paddr),
    .base_q    (base_q),
    .limit_q   (limit_q),
    .flags_q   (flags_q)
);

// File: tb/sim_seg_reloc_unit.sv
`timescale 1ns/1ps
module sim_seg_reloc_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_kind = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_exc;
    logic [31:0] rsp_paddr;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    seg_reloc_unit u0 (.*);

    // entry: {addr, kind, expected code, expected physical address}
    localparam logic [67:0] VEC [10] = '{
        {32'h0000_0010, 2'd0, 2'd0, 32'h1000_0010},
        {32'h0000_3FFF, 2'd1, 2'd0, 32'h1000_3FFF},
        {32'h0000_4000, 2'd0, 2'd2, 32'h0000_0000},
        {32'h0000_0100, 2'd2, 2'd3, 32'h0000_0000},
        {32'h8000_0020, 2'd2, 2'd0, 32'h8000_0020},
        {32'h8000_0020, 2'd1, 2'd3, 32'h0000_0000},
        {32'h8001_0000, 2'd2, 2'd2, 32'h0000_0000},
        {32'h8000_FFFF, 2'd0, 2'd0, 32'h8000_FFFF},
        {32'h0000_5000, 2'd2, 2'd2, 32'h0000_0000},
        {32'h0000_0010, 2'd3, 2'd3, 32'h0000_0000}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic access(input string tag, input logic [31:0] a, input logic [1:0] k,
                          input logic [1:0] exc, input logic [31:0] pa);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_kind = k;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " valid"}, {31'd0, rsp_valid}, 32'd1);
        check({tag, " code"}, {30'd0, rsp_exc}, {30'd0, exc});
        check({tag, " paddr"}, rsp_paddr, pa);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 20000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 rsp_valid in reset", {31'd0, rsp_valid}, 32'd0);
        check("R9 rsp_paddr in reset", rsp_paddr, 32'd0);
        rst_n = 1'b1;
        access("R9 first access absent", 32'h0000_0000, 2'd0, 2'd1, 32'd0);
        @(negedge clk);
        // R2 no pending response -> quiet outputs
        check("R2 idle valid", {31'd0, rsp_valid}, 32'd0);
        check("R2 idle code", {30'd0, rsp_exc}, 32'd0);

        // R8 program both segments: flags bit0 rd, bit1 wr, bit2 ex, bit3 present
        cfg_write(3'd0, 32'h1000_0000);
        cfg_write(3'd1, 32'h0000_4000);
        cfg_write(3'd2, 32'h0000_000B);
        cfg_write(3'd4, 32'h8000_0000);
        cfg_write(3'd5, 32'h0001_0000);
        cfg_write(3'd6, 32'h0000_000D);

        // R1 R2 R3 R5 R7 table walk
        foreach (VEC[i]) begin
            access($sformatf("R1/R2/R3/R5/R7 vector %0d", i), VEC[i][67:36],
                   VEC[i][35:34], VEC[i][33:32], VEC[i][31:0]);
        end

        // R8 field 3 ignored for both segments
        cfg_write(3'd3, 32'hFFFF_FFFF);
        cfg_write(3'd7, 32'h0000_0000);
        access("R8 ignored sel3", 32'h0000_0010, 2'd0, 2'd0, 32'h1000_0010);
        access("R8 ignored sel7", 32'h8000_0020, 2'd2, 2'd0, 32'h8000_0020);

        // R8 write in same cycle as request: request sees old base
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 3'd4; cfg_wdata = 32'h0200_0000;
        req_valid = 1'b1; req_addr = 32'h8000_0040; req_kind = 2'd0;
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0;
        check("R8 same-cycle old base", rsp_paddr, 32'h8000_0040);
        access("R8 new base applied", 32'h8000_0040, 2'd0, 2'd0, 32'h0200_0040);

        // R2 back-to-back requests
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h0000_0001; req_kind = 2'd0;
        @(negedge clk);
        req_addr = 32'h0000_0002; req_kind = 2'd1;
        check("R2 back-to-back first", rsp_paddr, 32'h1000_0001);
        @(negedge clk);
        req_valid = 1'b0;
        check("R2 back-to-back second", rsp_paddr, 32'h1000_0002);
        check("R2 back-to-back valid", {31'd0, rsp_valid}, 32'd1);
        @(negedge clk);
        check("R2 single-cycle pulse", {31'd0, rsp_valid}, 32'd0);

        // R4 carry out of base+offset
        cfg_write(3'd4, 32'hFFFF_F000);
        cfg_write(3'd5, 32'h7FFF_FFFF);
        access("R4 top address fits", 32'h8000_0FFF, 2'd0, 2'd0, 32'hFFFF_FFFF);
        access("R4 carry out", 32'h8000_1000, 2'd0, 2'd2, 32'd0);

        // R6 R7 absent beats bounds and rights
        cfg_write(3'd2, 32'h0000_0003);
        access("R6 absent segment", 32'h0000_0010, 2'd0, 2'd1, 32'd0);
        access("R7 absent over bounds", 32'h0000_9000, 2'd2, 2'd1, 32'd0);
        access("R1 other segment unaffected", 32'h8000_0010, 2'd2, 2'd0, 32'hFFFF_F010);

        // R3 limit zero faults every offset
        cfg_write(3'd2, 32'h0000_000F);
        cfg_write(3'd1, 32'h0000_0000);
        access("R3 zero limit", 32'h0000_0000, 2'd0, 2'd2, 32'd0);

        finish_run();
    end
endmodule